// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

A single-cycle router for one node of a 2D mesh. It has four neighbour links (north, east, south, west) and a local port through which the attached core injects and receives flits. There is no flit storage anywhere in the router. Every valid flit that arrives in a cycle is given an output in that same cycle, and is registered onto that output for the next cycle.

Each flit asks for one output, chosen by dimension-order routing: the X coordinate is corrected first, then Y. When two flits want the same link, the older one gets it. A flit that loses is deflected onto a free neighbour link, even if that link leads away from its destination. One flit that has reached this node leaves through the ejection port. The core may place a new flit in the network only if a neighbour link is still unused after through-traffic has been placed. If the core holds a flit and no link is free, the router signals starvation and the flit stays with the core.

Neighbour ports are indexed north = 0, east = 1, south = 2, west = 3. This index is used both for input and for output ports. X grows towards east and Y grows towards north.

Top module: `defl_router`

## Requirements
- R1: Every valid input flit leaves in the next cycle, either on exactly one neighbour output or on the ejection port. An accepted injection also appears on one output. No flit is dropped or duplicated.
- R2: An uncontested flit is routed as follows. If dst_x > MY_X it goes east (1). If dst_x < MY_X it goes west (3). If X matches and dst_y > MY_Y it goes north (0). If X matches and dst_y < MY_Y it goes south (2).
- R3: Flits are placed in order of descending age. Each takes its routed port if that port is still free; otherwise it takes the lowest-numbered free neighbour port.
- R4: When two flits have equal age, the one on the lower input index is placed first.
- R5: A flit whose destination equals (MY_X, MY_Y) is ejected on the ejection port, with its arriving age, one cycle later. At most one flit is ejected per cycle, and it is the highest-priority local flit. Other local flits are deflected to the lowest-numbered free neighbour port.
- R6: A forwarded flit leaves with its age plus one. The age saturates at 255 (8-bit field).
- R7: Injection is accepted (inj_rdy_o high) only when a neighbour output is free after through-traffic is placed. An ejected flit frees its slot for this purpose. The injected flit takes its routed port if free, otherwise the lowest-numbered free port, and it leaves with age INIT_AGE (0).
- R8: starve_o is high exactly when inj_vld_i is high and no output is free. In that case no injected data appears on any output.
- R9: After reset, no output and no ejection is valid.
- R10: An input whose valid bit is low takes no part in arbitration, whatever its age or destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 4 | Valid bit per neighbour input |
| in_dx_i | input | 4×X_W | Destination X per input |
| in_dy_i | input | 4×Y_W | Destination Y per input |
| in_age_i | input | 4×AGE_W | Age per input |
| in_data_i | input | 4×DATA_W | Payload per input |
| out_vld_o | output | 4 | Valid bit per neighbour output |
| out_dx_o | output | 4×X_W | Destination X per output |
| out_dy_o | output | 4×Y_W | Destination Y per output |
| out_age_o | output | 4×AGE_W | Updated age per output |
| out_data_o | output | 4×DATA_W | Payload per output |
| inj_vld_i | input | 1 | Core holds a flit to inject |
| inj_dx_i | input | X_W | Destination X of the injected flit |
| inj_dy_i | input | Y_W | Destination Y of the injected flit |
| inj_data_i | input | DATA_W | Payload of the injected flit |
| inj_rdy_o | output | 1 | Injection is taken this cycle |
| starve_o | output | 1 | Core wants to inject but no link is free |
| ej_vld_o | output | 1 | A flit is delivered to the core |
| ej_age_o | output | AGE_W | Age of the delivered flit |
| ej_data_o | output | DATA_W | Payload of the delivered flit |

## Verification
A wrong priority rank or a stale free-port mask shows up one cycle after the stimulus. The payload appears on the wrong neighbour output, two outputs carry the same flit, or the sum of valid outputs plus ejections no longer matches the arrivals. A fault in the ejection choice is visible at once on ej_data_o and ej_age_o, and at the same edge a local flit appears on a neighbour link. A fault in injection gating is visible in the cycle it happens, on inj_rdy_o and starve_o, before any clock edge.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int NB = 4;
  localparam int RW = $clog2(NB);

  localparam logic [2:0] P_N = 3'd0;
  localparam logic [2:0] P_E = 3'd1;
  localparam logic [2:0] P_S = 3'd2;
  localparam logic [2:0] P_W = 3'd3;
  localparam logic [2:0] P_L = 3'd4;

  function automatic logic [RW-1:0] low_free(input logic [NB-1:0] f);
    logic [RW-1:0] r;
    r = '0;
    for (int p = NB - 1; p >= 0; p--) begin
      if (f[p]) r = RW'(p);
    end
    return r;
  endfunction
endpackage

// File: rtl/defl_route.sv
module defl_route
  import defl_pkg::*;
#(
  parameter int X_W  = 3,
  parameter int Y_W  = 3,
  parameter int MY_X = 2,
  parameter int MY_Y = 2
) (
  input  logic [X_W-1:0] dx_i,
  input  logic [Y_W-1:0] dy_i,
  output logic [2:0]     port_o
);
  localparam logic [X_W-1:0] HX = X_W'(MY_X);
  localparam logic [Y_W-1:0] HY = Y_W'(MY_Y);

  // X first, then Y
  always_comb begin
    if (dx_i > HX)      port_o = P_E;
    else if (dx_i < HX) port_o = P_W;
    else if (dy_i > HY) port_o = P_N;
    else if (dy_i < HY) port_o = P_S;
    else                port_o = P_L;
  end
endmodule

// File: rtl/defl_rank.sv
module defl_rank
  import defl_pkg::*;
#(
  parameter int AGE_W = 8
) (
  input  logic [NB-1:0]            vld_i,
  input  logic [NB-1:0][AGE_W-1:0] age_i,
  output logic [NB-1:0][RW-1:0]    rank_o
);
  // rank = number of valid flits placed ahead (older, or same age on lower index)
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < NB; j++) begin
        if (j != i && vld_i[j] &&
            ((age_i[j] > age_i[i]) || (age_i[j] == age_i[i] && j < i)))
          cnt++;
      end
      rank_o[i] = RW'(cnt);
    end
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      for (int j = i + 1; j < NB; j++) begin
        p_rank_unique_r4: assert (!(vld_i[i] && vld_i[j]) || rank_o[i] != rank_o[j]);
      end
    end
  end
endmodule

// File: rtl/defl_alloc.sv
module defl_alloc
  import defl_pkg::*;
(
  input  logic [NB-1:0]         vld_i,
  input  logic [NB-1:0][RW-1:0] rank_i,
  input  logic [NB-1:0][2:0]    want_i,
  output logic [NB-1:0]         grant_o,
  output logic [NB-1:0][RW-1:0] gport_o,
  output logic [NB-1:0]         ej_sel_o,
  output logic [NB-1:0]         free_o
);
  always_comb begin
    logic [NB-1:0] free;
    logic          ej_done;
    logic [RW-1:0] pick;
    free     = '1;
    ej_done  = 1'b0;
    pick     = '0;
    grant_o  = '0;
    gport_o  = '0;
    ej_sel_o = '0;
    for (int k = 0; k < NB; k++) begin
      for (int i = 0; i < NB; i++) begin
        if (vld_i[i] && rank_i[i] == RW'(k)) begin
          if (want_i[i] == P_L && !ej_done) begin
            ej_sel_o[i] = 1'b1;
            ej_done     = 1'b1;
          end else begin
            if (want_i[i] != P_L && free[want_i[i][RW-1:0]]) pick = want_i[i][RW-1:0];
            else                                             pick = low_free(free);
            grant_o[i]  = 1'b1;
            gport_o[i]  = pick;
            free[pick]  = 1'b0;
          end
        end
      end
    end
    free_o = free;
  end
endmodule

// File: rtl/defl_router.sv
module defl_router
  import defl_pkg::*;
#(
  parameter int X_W      = 3,
  parameter int Y_W      = 3,
  parameter int AGE_W    = 8,
  parameter int DATA_W   = 16,
  parameter int MY_X     = 2,
  parameter int MY_Y     = 2,
  parameter int INIT_AGE = 0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NB-1:0]             in_vld_i,
  input  logic [NB-1:0][X_W-1:0]    in_dx_i,
  input  logic [NB-1:0][Y_W-1:0]    in_dy_i,
  input  logic [NB-1:0][AGE_W-1:0]  in_age_i,
  input  logic [NB-1:0][DATA_W-1:0] in_data_i,
  output logic [NB-1:0]             out_vld_o,
  output logic [NB-1:0][X_W-1:0]    out_dx_o,
  output logic [NB-1:0][Y_W-1:0]    out_dy_o,
  output logic [NB-1:0][AGE_W-1:0]  out_age_o,
  output logic [NB-1:0][DATA_W-1:0] out_data_o,
  input  logic                      inj_vld_i,
  input  logic [X_W-1:0]            inj_dx_i,
  input  logic [Y_W-1:0]            inj_dy_i,
  input  logic [DATA_W-1:0]         inj_data_i,
  output logic                      inj_rdy_o,
  output logic                      starve_o,
  output logic                      ej_vld_o,
  output logic [AGE_W-1:0]          ej_age_o,
  output logic [DATA_W-1:0]         ej_data_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] AGE_INI = AGE_W'(INIT_AGE);

  logic [NB-1:0][2:0]    want;
  logic [NB-1:0][RW-1:0] rank;
  logic [NB-1:0]         grant;
  logic [NB-1:0][RW-1:0] gport;
  logic [NB-1:0]         ej_sel;
  logic [NB-1:0]         free;
  logic [2:0]            inj_want;
  logic [RW-1:0]         inj_port;
  logic                  inj_fire;
  logic                  ej_fire;

  for (genvar g = 0; g < NB; g++) begin : g_route
    defl_route #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) i_route (
      .dx_i  (in_dx_i[g]),
      .dy_i  (in_dy_i[g]),
      .port_o(want[g])
    );
  end

  defl_route #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) i_inj_route (
    .dx_i  (inj_dx_i),
    .dy_i  (inj_dy_i),
    .port_o(inj_want)
  );

  defl_rank #(.AGE_W(AGE_W)) i_rank (
    .vld_i (in_vld_i),
    .age_i (in_age_i),
    .rank_o(rank)
  );

  defl_alloc i_alloc (
    .vld_i   (in_vld_i),
    .rank_i  (rank),
    .want_i  (want),
    .grant_o (grant),
    .gport_o (gport),
    .ej_sel_o(ej_sel),
    .free_o  (free)
  );

  assign inj_rdy_o = |free;
  assign starve_o  = inj_vld_i & ~inj_rdy_o;
  assign inj_fire  = inj_vld_i & inj_rdy_o;
  assign ej_fire   = |ej_sel;

  always_comb begin
    if (inj_want != P_L && free[inj_want[RW-1:0]]) inj_port = inj_want[RW-1:0];
    else                                           inj_port = low_free(free);
  end

  logic [NB-1:0]             nxt_vld;
  logic [NB-1:0][X_W-1:0]    nxt_dx;
  logic [NB-1:0][Y_W-1:0]    nxt_dy;
  logic [NB-1:0][AGE_W-1:0]  nxt_age;
  logic [NB-1:0][DATA_W-1:0] nxt_data;
  logic [AGE_W-1:0]          nxt_ej_age;
  logic [DATA_W-1:0]         nxt_ej_data;

  always_comb begin
    nxt_vld     = '0;
    nxt_dx      = '0;
    nxt_dy      = '0;
    nxt_age     = '0;
    nxt_data    = '0;
    nxt_ej_age  = '0;
    nxt_ej_data = '0;
    for (int p = 0; p < NB; p++) begin
      for (int i = 0; i < NB; i++) begin
        if (grant[i] && gport[i] == RW'(p)) begin
          nxt_vld[p]  = 1'b1;
          nxt_dx[p]   = in_dx_i[i];
          nxt_dy[p]   = in_dy_i[i];
          nxt_age[p]  = (in_age_i[i] == AGE_MAX) ? AGE_MAX : in_age_i[i] + 1'b1;
          nxt_data[p] = in_data_i[i];
        end
      end
      if (inj_fire && inj_port == RW'(p)) begin
        nxt_vld[p]  = 1'b1;
        nxt_dx[p]   = inj_dx_i;
        nxt_dy[p]   = inj_dy_i;
        nxt_age[p]  = AGE_INI;
        nxt_data[p] = inj_data_i;
      end
    end
    for (int i = 0; i < NB; i++) begin
      if (ej_sel[i]) begin
        nxt_ej_age  = in_age_i[i];
        nxt_ej_data = in_data_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o  <= '0;
      out_dx_o   <= '0;
      out_dy_o   <= '0;
      out_age_o  <= '0;
      out_data_o <= '0;
      ej_vld_o   <= 1'b0;
      ej_age_o   <= '0;
      ej_data_o  <= '0;
    end else begin
      out_vld_o  <= nxt_vld;
      out_dx_o   <= nxt_dx;
      out_dy_o   <= nxt_dy;
      out_age_o  <= nxt_age;
      out_data_o <= nxt_data;
      ej_vld_o   <= ej_fire;
      ej_age_o   <= nxt_ej_age;
      ej_data_o  <= nxt_ej_data;
    end
  end

  // ---- assertions ----
  logic [3:0] arr_cnt;
  assign arr_cnt = 4'($countones(in_vld_i)) + 4'(inj_fire);

  p_conserve_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (32'($countones(out_vld_o)) + 32'(ej_vld_o)) == 32'($past(arr_cnt)));

  p_starve_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    starve_o |-> ((&in_vld_i) && !ej_fire));

  p_inj_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_fire |-> (!(&in_vld_i) || ej_fire));

  for (genvar g = 0; g < NB; g++) begin : g_chk
    p_local_eject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o[g] && out_age_o[g] != AGE_INI &&
       out_dx_o[g] == X_W'(MY_X) && out_dy_o[g] == Y_W'(MY_Y)) |-> ej_vld_o);
  end
endmodule

// File: tb/test_defl_router.sv
`timescale 1ns/1ps
module test_defl_router;
  localparam int X_W = 3, Y_W = 3, AGE_W = 8, DATA_W = 16;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [3:0]             in_vld;
  logic [3:0][X_W-1:0]    in_dx;
  logic [3:0][Y_W-1:0]    in_dy;
  logic [3:0][AGE_W-1:0]  in_age;
  logic [3:0][DATA_W-1:0] in_data;
  logic [3:0]             out_vld;
  logic [3:0][X_W-1:0]    out_dx;
  logic [3:0][Y_W-1:0]    out_dy;
  logic [3:0][AGE_W-1:0]  out_age;
  logic [3:0][DATA_W-1:0] out_data;
  logic                   inj_vld;
  logic [X_W-1:0]         inj_dx;
  logic [Y_W-1:0]         inj_dy;
  logic [DATA_W-1:0]      inj_data;
  logic                   inj_rdy, starve, ej_vld;
  logic [AGE_W-1:0]       ej_age;
  logic [DATA_W-1:0]      ej_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  defl_router i_defl_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_vld_i(in_vld), .in_dx_i(in_dx), .in_dy_i(in_dy), .in_age_i(in_age), .in_data_i(in_data),
    .out_vld_o(out_vld), .out_dx_o(out_dx), .out_dy_o(out_dy), .out_age_o(out_age),
    .out_data_o(out_data),
    .inj_vld_i(inj_vld), .inj_dx_i(inj_dx), .inj_dy_i(inj_dy), .inj_data_i(inj_data),
    .inj_rdy_o(inj_rdy), .starve_o(starve),
    .ej_vld_o(ej_vld), .ej_age_o(ej_age), .ej_data_o(ej_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    in_vld = '0; in_dx = '0; in_dy = '0; in_age = '0; in_data = '0;
    inj_vld = 1'b0; inj_dx = '0; inj_dy = '0; inj_data = '0;
  endtask

  task automatic put(input int p, input int dx, input int dy, input int age, input int data);
    in_vld[p]  = 1'b1;
    in_dx[p]   = X_W'(dx);
    in_dy[p]   = Y_W'(dy);
    in_age[p]  = AGE_W'(age);
    in_data[p] = DATA_W'(data);
  endtask

  task automatic inj(input int dx, input int dy, input int data);
    inj_vld = 1'b1; inj_dx = X_W'(dx); inj_dy = Y_W'(dy); inj_data = DATA_W'(data);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R9 out_vld", 32'(out_vld), 0);
    chk("R9 ej_vld", 32'(ej_vld), 0);
  endtask

  task automatic t_route();
    clr();
    put(0, 3, 2, 10, 'hA0); put(1, 0, 2, 11, 'hA1);
    put(2, 2, 4, 12, 'hA2); put(3, 2, 1, 13, 'hA3);
    step(); clr();
    chk("R2 vld", 32'(out_vld), 'hF);
    chk("R2 east", 32'(out_data[1]), 'hA0);
    chk("R2 west", 32'(out_data[3]), 'hA1);
    chk("R2 north", 32'(out_data[0]), 'hA2);
    chk("R2 south", 32'(out_data[2]), 'hA3);
    chk("R6 inc", 32'(out_age[1]), 11);
  endtask

  task automatic t_contend();
    clr();
    put(0, 4, 2, 5, 'hB0); put(2, 4, 2, 9, 'hB2);
    step(); clr();
    chk("R3 vld", 32'(out_vld), 'h3);
    chk("R3 winner east", 32'(out_data[1]), 'hB2);
    chk("R3 winner age", 32'(out_age[1]), 10);
    chk("R3 deflect north", 32'(out_data[0]), 'hB0);
  endtask

  task automatic t_tie();
    clr();
    put(1, 2, 5, 7, 'hC1); put(3, 2, 5, 7, 'hC3);
    step(); clr();
    chk("R4 low index wins", 32'(out_data[0]), 'hC1);
    chk("R4 loser lowest free", 32'(out_data[1]), 'hC3);
    chk("R4 vld", 32'(out_vld), 'h3);
  endtask

  task automatic t_eject();
    clr();
    put(0, 2, 2, 3, 'hD0); put(2, 2, 2, 6, 'hD2);
    step(); clr();
    chk("R5 ej_vld", 32'(ej_vld), 1);
    chk("R5 ej oldest", 32'(ej_data), 'hD2);
    chk("R5 ej age", 32'(ej_age), 6);
    chk("R5 second deflected", 32'(out_vld), 'h1);
    chk("R5 second data", 32'(out_data[0]), 'hD0);
    chk("R1 count", 32'($countones(out_vld)) + 32'(ej_vld), 2);
  endtask

  task automatic t_sat();
    clr();
    put(0, 4, 2, 255, 'hE0); put(1, 0, 2, 254, 'hE1);
    step(); clr();
    chk("R6 saturate", 32'(out_age[1]), 255);
    chk("R6 reach max", 32'(out_age[3]), 255);
  endtask

  task automatic t_inject();
    clr();
    inj(4, 2, 'hF0);
    #1;
    chk("R7 rdy idle", 32'(inj_rdy), 1);
    chk("R8 no starve", 32'(starve), 0);
    step(); clr();
    chk("R7 inj east", 32'(out_data[1]), 'hF0);
    chk("R7 inj age", 32'(out_age[1]), 0);
    chk("R7 inj vld", 32'(out_vld), 'h2);
    // east taken by through traffic
    put(0, 4, 2, 1, 'h10); put(1, 2, 5, 2, 'h11); put(2, 2, 0, 3, 'h12);
    inj(4, 2, 'hF1);
    #1;
    chk("R7 rdy one free", 32'(inj_rdy), 1);
    step(); clr();
    chk("R7 inj deflected west", 32'(out_data[3]), 'hF1);
    chk("R7 through east", 32'(out_data[1]), 'h10);
    chk("R1 all out", 32'(out_vld), 'hF);
  endtask

  task automatic t_starve();
    clr();
    put(0, 4, 2, 1, 'h20); put(1, 4, 2, 2, 'h21);
    put(2, 4, 2, 3, 'h22); put(3, 4, 2, 4, 'h23);
    inj(0, 2, 'hF2);
    #1;
    chk("R8 starve", 32'(starve), 1);
    chk("R7 not ready", 32'(inj_rdy), 0);
    step();
    chk("R1 four out", 32'(out_vld), 'hF);
    chk("R3 oldest east", 32'(out_data[1]), 'h23);
    chk("R3 youngest west", 32'(out_data[3]), 'h20);
    for (int p = 0; p < 4; p++) chk("R8 no inj data", 32'(out_data[p] == 16'hF2), 0);
    // input 0 now local: its ejection frees a slot
    in_dx[0] = 3'd2;
    #1;
    chk("R7 rdy after eject", 32'(inj_rdy), 1);
    chk("R8 starve cleared", 32'(starve), 0);
    step(); clr();
    chk("R5 ej", 32'(ej_data), 'h20);
    chk("R7 inj in freed slot", 32'(out_data[3]), 'hF2);
    chk("R1 count", 32'($countones(out_vld)) + 32'(ej_vld), 5);
  endtask

  task automatic t_invalid();
    clr();
    put(3, 4, 2, 255, 'h33); in_vld[3] = 1'b0;
    put(0, 4, 2, 1, 'h30);
    step(); clr();
    chk("R10 vld", 32'(out_vld), 'h2);
    chk("R10 east", 32'(out_data[1]), 'h30);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    clr();
    #12 rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_contend();
    t_tie();
    t_eject();
    t_sat();
    t_inject();
    t_starve();
    t_invalid();
    step();
    finish_run();
  end
endmodule